// File: doc/BRIEF.md
# Batch Serial Transmitter with Resynchronisation Guard

This block sends a fixed-length batch of bytes over an asynchronous serial line that carries no clock. Each byte goes out in a ten-bit frame: one low start bit, eight data bits with the least significant bit first, and one high stop bit. The frames of a batch follow each other with no idle time between them. An external divider supplies a one-cycle `bit_tick` pulse, and each pulse moves the line on by exactly one bit time.

After the stop bit of the last byte, the block holds the line high for a guard interval measured in bit times. The guard is longer than one whole frame. A frame always contains a low bit, so a receiver that has lost its place in the stream sees a run of high bits that can only be the gap, and it locks onto the next falling edge as a true start bit.

The guard length comes from a setting register that resets to 11. The block never uses less than a floor that rises with the batch length: one frame plus one bit for each eight bytes of batch. A batch is accepted by a valid/ready handshake. Ready stays low from acceptance until the last guard bit has elapsed.

States: `ST_IDLE` (line high, ready high), `ST_SEND` (frames on the line), `ST_GUARD` (line high, counting guard bits). Transitions: `ST_IDLE`→`ST_SEND` on handshake; `ST_SEND`→`ST_SEND` (next byte loaded) on the final tick of a non-last frame; `ST_SEND`→`ST_GUARD` on the final tick of the last frame; `ST_GUARD`→`ST_IDLE` on the tick that ends the guard.

Top module: `batch_serial_tx`

## Requirements
- R1: After reset, `serial_out` is 1 and `batch_ready` is 1.
- R2: Whenever `batch_ready` is 1, `serial_out` is 1.
- R3: On a clock edge where `batch_valid` and `batch_ready` are both 1, the payload is captured. In the next cycle `batch_ready` is 0 and `serial_out` is 0, which is the start bit of byte 0.
- R4: Each byte is sent as the sequence 0, data bit 0 through data bit 7, then 1. Each `bit_tick` pulse ends the current bit, and the line does not change between ticks.
- R5: Byte k is taken from payload bits [8k+7:8k]. Bytes go out in order k = 0 to BYTES-1, and each frame starts on the tick that ends the stop bit of the frame before it.
- R6: After the last stop bit, the line stays 1 for exactly G ticks with `batch_ready` at 0. `batch_ready` returns to 1 on the G-th guard tick, so the busy period lasts BYTES*10+G ticks.
- R7: G equals the guard setting, or the floor 10 + BYTES/8 (11 at default parameters) when the setting is smaller than the floor.
- R8: The guard setting resets to 11. It is loaded from `guard_len` on a cycle where `guard_we` is 1, and the next batch uses the new value.
- R9: `batch_valid` and `batch_data` have no effect while `batch_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| batch_valid | input | 1 | Batch offered |
| batch_ready | output | 1 | Block can accept a batch |
| batch_data | input | BYTES*DATA_BITS | Payload, byte 0 in the low bits |
| bit_tick | input | 1 | One pulse per bit time |
| guard_we | input | 1 | Load the guard setting |
| guard_len | input | GUARD_W | New guard length in bit times |
| serial_out | output | 1 | Serial line, idle high |

## Verification
The bench builds the block with its default parameters: eight-byte batches, eight data bits and an eight-bit guard setting that resets to 11. With these values the floor of 11 equals the reset value, so three cases are tested: the reset value, a setting below the floor that gets raised to it, and a larger setting that is used as written. Each batch lasts about a hundred ticks, which is long enough to drive a noisy handshake in the middle of a transfer and to check every bit of several distinct payloads against their frame order.

// File: rtl/bstx_pkg.sv
package bstx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_GUARD = 2'd2
    } tx_state_e;
endpackage

// File: rtl/bstx_frame_shift.sv
// Holds one start/data/stop frame and shifts it out one bit per advance.
module bstx_frame_shift #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] load_byte,
    input  logic                 advance,
    output logic                 line_bit,
    output logic                 frame_done
);
    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      bit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '1;
            bit_cnt <= '0;
        end else if (load) begin
            shreg   <= {1'b1, load_byte, 1'b0};
            bit_cnt <= '0;
        end else if (advance) begin
            shreg   <= {1'b1, shreg[FRAME_BITS-1:1]};
            bit_cnt <= bit_cnt + CNT_W'(1);
        end
    end

    assign line_bit   = shreg[0];
    assign frame_done = advance && (bit_cnt == CNT_W'(FRAME_BITS - 1));
endmodule

// File: rtl/bstx_guard_timer.sv
// Guard setting register with floor clamp, and the guard countdown.
module bstx_guard_timer #(
    parameter int GUARD_W   = 8,
    parameter int GUARD_RST = 11,
    parameter int MIN_GUARD = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [GUARD_W-1:0] cfg_len,
    input  logic               start,
    input  logic               advance,
    output logic               done
);
    logic [GUARD_W-1:0] guard_cfg;
    logic [GUARD_W-1:0] guard_eff;
    logic [GUARD_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      guard_cfg <= GUARD_W'(GUARD_RST);
        else if (cfg_we) guard_cfg <= cfg_len;
    end

    always_comb begin
        if (guard_cfg < GUARD_W'(MIN_GUARD)) guard_eff = GUARD_W'(MIN_GUARD);
        else                                 guard_eff = guard_cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       remain <= '0;
        else if (start)                   remain <= guard_eff;
        else if (advance && remain != '0) remain <= remain - GUARD_W'(1);
    end

    assign done = advance && (remain == GUARD_W'(1));
endmodule

// File: rtl/batch_serial_tx.sv
module batch_serial_tx #(
    parameter int BYTES     = 8,
    parameter int DATA_BITS = 8,
    parameter int GUARD_W   = 8,
    parameter int GUARD_RST = 11
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         batch_valid,
    output logic                         batch_ready,
    input  logic [BYTES*DATA_BITS-1:0]   batch_data,
    input  logic                         bit_tick,
    input  logic                         guard_we,
    input  logic [GUARD_W-1:0]           guard_len,
    output logic                         serial_out
);
    import bstx_pkg::*;

    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int MIN_GUARD  = FRAME_BITS + BYTES / 8;
    localparam int IDX_W      = (BYTES > 1) ? $clog2(BYTES) : 1;

    tx_state_e state, state_nxt;

    logic [BYTES*DATA_BITS-1:0] payload;
    logic [DATA_BITS-1:0]       byte_lane [BYTES];
    logic [IDX_W-1:0]           byte_idx;
    logic [IDX_W-1:0]           nxt_idx;
    logic                       last_byte;
    logic                       accept;
    logic                       send_adv, guard_adv;
    logic                       frame_done, guard_done;
    logic                       shift_load, line_bit;
    logic [DATA_BITS-1:0]       shift_byte;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign byte_lane[g] = payload[g*DATA_BITS +: DATA_BITS];
    end

    assign accept    = batch_valid && batch_ready;
    assign send_adv  = bit_tick && (state == ST_SEND);
    assign guard_adv = bit_tick && (state == ST_GUARD);
    assign nxt_idx   = byte_idx + IDX_W'(1);
    assign last_byte = (byte_idx == IDX_W'(BYTES - 1));

    assign shift_load = accept || (frame_done && !last_byte);
    assign shift_byte = accept ? batch_data[DATA_BITS-1:0] : byte_lane[nxt_idx];

    bstx_frame_shift #(.DATA_BITS(DATA_BITS)) i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (shift_load),
        .load_byte  (shift_byte),
        .advance    (send_adv),
        .line_bit   (line_bit),
        .frame_done (frame_done)
    );

    bstx_guard_timer #(
        .GUARD_W   (GUARD_W),
        .GUARD_RST (GUARD_RST),
        .MIN_GUARD (MIN_GUARD)
    ) i_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (guard_we),
        .cfg_len (guard_len),
        .start   (frame_done && last_byte),
        .advance (guard_adv),
        .done    (guard_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            payload  <= '0;
            byte_idx <= '0;
        end else if (accept) begin
            payload  <= batch_data;
            byte_idx <= '0;
        end else if (frame_done && !last_byte) begin
            byte_idx <= nxt_idx;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nxt = ST_SEND;
            ST_SEND:  if (frame_done && last_byte) state_nxt = ST_GUARD;
            ST_GUARD: if (guard_done) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        batch_ready = 1'b0;
        serial_out  = 1'b1;
        unique case (state)
            ST_IDLE:  batch_ready = 1'b1;
            ST_SEND:  serial_out  = line_bit;
            ST_GUARD: serial_out  = 1'b1;
            default:  serial_out  = 1'b1;
        endcase
    end
endmodule

// File: rtl/bstx_chk.sv
module bstx_chk (
    input logic clk,
    input logic rst_n,
    input logic batch_valid,
    input logic batch_ready,
    input logic bit_tick,
    input logic serial_out
);
    // R2
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        batch_ready |-> serial_out);

    // R3
    start_bit_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(batch_ready) |-> (!serial_out && $past(batch_valid)));

    // R4
    line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(serial_out) |-> ($past(bit_tick) || $past(batch_valid && batch_ready)));

    // R6
    ready_returns_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(batch_ready) |-> ($past(bit_tick) && $past(serial_out)));

    // R9
    busy_stays_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!batch_ready && !bit_tick) |=> !batch_ready);
endmodule

bind batch_serial_tx bstx_chk i_bstx_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .batch_valid (batch_valid),
    .batch_ready (batch_ready),
    .bit_tick    (bit_tick),
    .serial_out  (serial_out)
);

// File: tb/test_batch_serial_tx.sv
module test_batch_serial_tx;
    localparam int BYTES     = 8;
    localparam int DB        = 8;
    localparam int GW        = 8;
    localparam int FLOOR     = 10 + BYTES / 8;
    localparam int PW        = BYTES * DB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          batch_valid = 1'b0;
    logic          batch_ready;
    logic [PW-1:0] batch_data = '0;
    logic          bit_tick = 1'b0;
    logic          guard_we = 1'b0;
    logic [GW-1:0] guard_len = '0;
    logic          serial_out;

    int checks = 0;
    int fails  = 0;
    int guard_model = 11;   // R8 reset value

    logic exp_bits[$];
    int   exp_ticks[$];
    int   tick_cnt = 0;
    logic prev_ready = 1'b1;

    batch_serial_tx #(.BYTES(BYTES), .DATA_BITS(DB), .GUARD_W(GW), .GUARD_RST(11)) i_batch_serial_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .batch_valid (batch_valid),
        .batch_ready (batch_ready),
        .batch_data  (batch_data),
        .bit_tick    (bit_tick),
        .guard_we    (guard_we),
        .guard_len   (guard_len),
        .serial_out  (serial_out)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // tick generator: one pulse every 4 cycles, driven at negedge
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
        end
    end

    // monitor: compares line bits and busy length against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (batch_ready) check(serial_out == 1'b1, "R2", serial_out, 1);
            if (bit_tick && !batch_ready) begin
                tick_cnt++;
                if (exp_bits.size() == 0) begin
                    check(1'b0, "R6", tick_cnt, 0);
                end else begin
                    logic e;
                    e = exp_bits.pop_front();
                    check(serial_out == e, "R4/R5", serial_out, e);
                end
            end
            if (batch_ready && !prev_ready) begin
                if (exp_ticks.size() == 0) check(1'b0, "R6", tick_cnt, -1);
                else begin
                    int et;
                    et = exp_ticks.pop_front();
                    check(tick_cnt == et, "R6/R7", tick_cnt, et);
                end
                tick_cnt = 0;
            end
            prev_ready = batch_ready;
        end
    end

    task automatic set_guard(input int v);
        while (!batch_ready) @(negedge clk);
        guard_we  = 1'b1;
        guard_len = GW'(v);
        @(negedge clk);
        guard_we  = 1'b0;
        guard_model = v;
    endtask

    task automatic send_batch(input logic [PW-1:0] d, input bit noise);
        int g;
        g = (guard_model < FLOOR) ? FLOOR : guard_model;
        while (!batch_ready) @(negedge clk);
        for (int b = 0; b < BYTES; b++) begin
            exp_bits.push_back(1'b0);
            for (int i = 0; i < DB; i++) exp_bits.push_back(d[b*DB + i]);
            exp_bits.push_back(1'b1);
        end
        for (int i = 0; i < g; i++) exp_bits.push_back(1'b1);
        exp_ticks.push_back(BYTES * 10 + g);
        batch_valid = 1'b1;
        batch_data  = d;
        @(negedge clk);
        batch_valid = 1'b0;
        // R3: start bit right after accept
        check(batch_ready == 1'b0, "R3", batch_ready, 0);
        check(serial_out == 1'b0, "R3", serial_out, 0);
        if (noise) begin
            // R9: junk handshake while busy must not alter the stream
            repeat (30) @(negedge clk);
            batch_valid = 1'b1;
            batch_data  = ~d;
            repeat (20) @(negedge clk);
            batch_valid = 1'b0;
            batch_data  = '0;
        end
        while (!batch_ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(serial_out == 1'b1, "R1", serial_out, 1);
        check(batch_ready == 1'b1, "R1", batch_ready, 1);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(serial_out == 1'b1, "R1", serial_out, 1);

        send_batch(64'h8877_6655_4433_2211, 1'b0);          // R8 reset guard
        send_batch(64'h0000_0000_0000_0000, 1'b0);          // R5 all zero
        set_guard(3);                                       // R7 below floor
        send_batch(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        set_guard(20);                                      // R8 larger value
        send_batch(64'hA55A_C33C_0FF0_8001, 1'b1);          // R9 noise
        set_guard(FLOOR);                                   // R7 at floor
        send_batch(64'h0123_4567_89AB_CDEF, 1'b0);

        repeat (20) @(negedge clk);
        check(exp_bits.size() == 0, "R6", exp_bits.size(), 0);
        check(exp_ticks.size() == 0, "R6", exp_ticks.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule